// File: doc/BRIEF.md
# Buck Converter Light-Load Mode Selector

This block decides whether a synchronous buck converter runs in fixed-frequency PWM mode or in hysteretic light-load mode. Once per switching cycle, a strobe marks the end of the low-side conduction interval, just before the high-side switch turns on. On that strobe the block reads a phase-polarity comparator bit. A high bit means the phase node is positive, so inductor current is reversing. A low bit means the phase node is negative, so current is flowing forward.

A run of same-polarity samples is needed before the mode changes. In PWM mode, a run of positive samples moves the block to hysteretic mode. In hysteretic mode, a run of negative samples moves it back to PWM. The need for a full run in each direction stops the mode from chattering near the load boundary. An output-undervoltage bit gives a fast exit to PWM on a switching-clock tick. A force-PWM pin pins the block to PWM mode. The outputs are the current mode, a one-cycle change pulse, and a one-cycle command that turns both switches off on entry to hysteretic mode.

All pins are plain level or strobe control signals. No streamed data crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `buck_mode_sel`

## Requirements
- R1: After reset the block is in PWM mode (`mode_hyst` = 0), with the run count at zero and both `mode_chg` and `gates_off` low.
- R2: The phase comparator is read only on clock edges where `smp_stb` is high. `phase_pos` has no effect on any other edge.
- R3: In PWM mode, the eighth consecutive strobed sample with `phase_pos` = 1 sets `mode_hyst` to 1 at the clock edge that captures that strobe. After seven such samples the block stays in PWM mode.
- R4: A strobed sample of the polarity that does not count toward a change restarts the run. Eight fresh qualifying samples are then needed.
- R5: In hysteretic mode, the eighth consecutive strobed sample with `phase_pos` = 0 returns the block to PWM mode at the capturing edge.
- R6: In hysteretic mode, `uv_low` = 1 on an edge where `cyc_tick` = 1 returns the block to PWM mode at that edge, without waiting for a run. `uv_low` on an edge without `cyc_tick` is ignored, and `uv_low` has no effect while the block is in PWM mode.
- R7: While `force_pwm` = 1, the mode is PWM from the next edge on, and the run count is held at zero. Priority is force first, then the undervoltage exit, then the sample run.
- R8: `mode_chg` is high for exactly the one cycle after each edge at which the mode changes, in either direction, and is low otherwise.
- R9: `gates_off` is high for exactly one cycle after a PWM-to-hysteretic change, and never after a hysteretic-to-PWM change.
- R10: The run count is cleared on every mode change, so samples taken before a change never count toward the next change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One-cycle pulse per switching cycle |
| smp_stb | input | 1 | End of low-side conduction; the edge where phase is sampled |
| phase_pos | input | 1 | Phase comparator: 1 = positive phase node |
| uv_low | input | 1 | Output is below the hysteretic regulation level |
| force_pwm | input | 1 | Hold the block in PWM mode |
| mode_hyst | output | 1 | 0 = PWM mode, 1 = hysteretic mode |
| mode_chg | output | 1 | One-cycle pulse after any mode change |
| gates_off | output | 1 | One-cycle command to turn both switches off on hysteretic entry |

## Verification
The bench feeds runs of seven samples and then an eighth. An off-by-one in the run length would change the mode one sample early or one sample late. It breaks runs with one opposite sample, which catches a counter that only pauses instead of restarting. It leaves a partial run in progress across an undervoltage exit and across a force pulse, so a design that keeps stale counts would switch after too few fresh samples. It also holds `phase_pos` and `uv_low` without their strobe and tick, which exposes a design that ignores the qualifiers, and it checks that the switch-off command does not fire on the return to PWM.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_HYST = 1'b1
  } mode_e;

endpackage

// File: rtl/mode_sample_qual.sv
module mode_sample_qual
  import buck_mode_pkg::*;
(
  input  mode_e mode,
  input  logic  smp_stb,
  input  logic  phase_pos,
  output logic  hit,
  output logic  miss
);

  logic toward_change;

  // In PWM, positive phase (reverse current) points toward hysteretic mode;
  // in hysteretic mode, negative phase (forward current) points back to PWM.
  always_comb begin
    if (mode == MODE_PWM) toward_change = phase_pos;
    else                  toward_change = ~phase_pos;
    hit  = smp_stb &  toward_change;
    miss = smp_stb & ~toward_change;
  end

endmodule

// File: rtl/mode_run_counter.sv
module mode_run_counter #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  input  logic miss,
  output logic done
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt;

  assign done = hit && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || miss) begin
      cnt <= '0;
    end else if (hit && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BELOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(RUN_LEN)) else $error("run count out of range"); // R3
  AST_MISS_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> cnt == '0) else $error("opposite sample did not restart run"); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0) else $error("clear did not empty run count"); // R10

endmodule

// File: rtl/mode_state.sv
module mode_state
  import buck_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cyc_tick,
  input  logic  uv_low,
  input  logic  force_pwm,
  input  logic  run_done,
  output mode_e mode,
  output logic  cnt_clr,
  output logic  chg_pulse,
  output logic  off_pulse
);

  mode_e nxt;

  always_comb begin
    nxt = mode;
    if (force_pwm) begin
      nxt = MODE_PWM;
    end else if (mode == MODE_HYST && cyc_tick && uv_low) begin
      nxt = MODE_PWM;
    end else if (run_done) begin
      nxt = (mode == MODE_PWM) ? MODE_HYST : MODE_PWM;
    end
    cnt_clr = force_pwm || (nxt != mode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= MODE_PWM;
      chg_pulse <= 1'b0;
      off_pulse <= 1'b0;
    end else begin
      mode      <= nxt;
      chg_pulse <= (nxt != mode);
      off_pulse <= (mode == MODE_PWM) && (nxt == MODE_HYST);
    end
  end

  AST_FORCE_HOLDS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    force_pwm |=> mode == MODE_PWM) else $error("force did not hold PWM"); // R7
  AST_UV_FAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HYST && cyc_tick && uv_low) |=> mode == MODE_PWM)
    else $error("undervoltage exit missed"); // R6
  AST_CHG_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pulse == (mode != $past(mode))) else $error("change pulse mismatch"); // R8
  AST_OFF_ON_ENTRY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    off_pulse |-> (mode == MODE_HYST && chg_pulse)) else $error("switch-off pulse misplaced"); // R9
  AST_ENTRY_HAS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HYST && $past(mode) == MODE_PWM) |-> off_pulse)
    else $error("entry without switch-off pulse"); // R9

endmodule

// File: rtl/buck_mode_sel.sv
module buck_mode_sel
  import buck_mode_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_tick,
  input  logic smp_stb,
  input  logic phase_pos,
  input  logic uv_low,
  input  logic force_pwm,
  output logic mode_hyst,
  output logic mode_chg,
  output logic gates_off
);

  mode_e mode;
  logic  hit, miss, run_done, cnt_clr;

  mode_sample_qual u_qual (
    .mode      (mode),
    .smp_stb   (smp_stb),
    .phase_pos (phase_pos),
    .hit       (hit),
    .miss      (miss)
  );

  mode_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .hit   (hit),
    .miss  (miss),
    .done  (run_done)
  );

  mode_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_tick  (cyc_tick),
    .uv_low    (uv_low),
    .force_pwm (force_pwm),
    .run_done  (run_done),
    .mode      (mode),
    .cnt_clr   (cnt_clr),
    .chg_pulse (mode_chg),
    .off_pulse (gates_off)
  );

  assign mode_hyst = (mode == MODE_HYST);

  AST_NO_CHANGE_WITHOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb && !force_pwm && !(cyc_tick && uv_low)) |=> !mode_chg)
    else $error("mode changed with no cause"); // R2

endmodule

// File: tb/buck_mode_sel_bench.sv
module buck_mode_sel_bench;

  logic clk = 1'b0;
  logic rst_n, cyc_tick, smp_stb, phase_pos, uv_low, force_pwm;
  logic mode_hyst, mode_chg, gates_off;
  int   checks = 0;
  int   fails  = 0;

  always #4 clk = ~clk;

  buck_mode_sel u_buck_mode_sel (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .smp_stb(smp_stb),
    .phase_pos(phase_pos), .uv_low(uv_low), .force_pwm(force_pwm),
    .mode_hyst(mode_hyst), .mode_chg(mode_chg), .gates_off(gates_off)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cyc_tick = 0; smp_stb = 0; phase_pos = 0; uv_low = 0; force_pwm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // one strobed sample; returns at the negedge after the capturing edge
  task automatic sample(input logic pos);
    smp_stb = 1; phase_pos = pos;
    @(negedge clk);
    smp_stb = 0; phase_pos = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_hyst();
    for (int i = 0; i < 8; i++) sample(1'b1);
    idle(1);
  endtask

  task automatic t_reset();
    do_reset();
    idle(1);
    chk("R1 mode", mode_hyst, 1'b0);
    chk("R1 chg", mode_chg, 1'b0);
    chk("R1 off", gates_off, 1'b0);
    for (int i = 0; i < 7; i++) sample(1'b1);
    chk("R1 count starts at zero", mode_hyst, 1'b0);
  endtask

  task automatic t_enter();
    do_reset();
    for (int i = 0; i < 7; i++) sample(1'b1);
    chk("R3 seven positive stay PWM", mode_hyst, 1'b0);
    sample(1'b1);
    chk("R3 eighth positive enters hyst", mode_hyst, 1'b1);
    chk("R8 chg on entry", mode_chg, 1'b1);
    chk("R9 off on entry", gates_off, 1'b1);
    idle(1);
    chk("R8 chg one cycle", mode_chg, 1'b0);
    chk("R9 off one cycle", gates_off, 1'b0);
  endtask

  task automatic t_unstrobed();
    do_reset();
    phase_pos = 1;
    idle(20);
    chk("R2 phase without strobe", mode_hyst, 1'b0);
    phase_pos = 0;
    for (int i = 0; i < 7; i++) sample(1'b1);
    chk("R2 no hidden count", mode_hyst, 1'b0);
  endtask

  task automatic t_break();
    do_reset();
    for (int i = 0; i < 5; i++) sample(1'b1);
    sample(1'b0);
    for (int i = 0; i < 7; i++) sample(1'b1);
    chk("R4 broken run stays PWM", mode_hyst, 1'b0);
    sample(1'b1);
    chk("R4 fresh run of eight enters", mode_hyst, 1'b1);
  endtask

  task automatic t_exit();
    do_reset();
    enter_hyst();
    for (int i = 0; i < 4; i++) sample(1'b0);
    sample(1'b1);
    for (int i = 0; i < 7; i++) sample(1'b0);
    chk("R5 seven negative stay hyst", mode_hyst, 1'b1);
    sample(1'b0);
    chk("R5 eighth negative exits", mode_hyst, 1'b0);
    chk("R8 chg on exit", mode_chg, 1'b1);
    chk("R9 no off on exit", gates_off, 1'b0);
  endtask

  task automatic t_uv();
    do_reset();
    uv_low = 1;
    idle(3);
    cyc_tick = 1; @(negedge clk); cyc_tick = 0;
    uv_low = 0;
    chk("R6 uv in PWM no effect", mode_chg, 1'b0);
    enter_hyst();
    uv_low = 1;
    idle(4);
    chk("R6 uv without tick ignored", mode_hyst, 1'b1);
    for (int i = 0; i < 4; i++) sample(1'b0);
    cyc_tick = 1; @(negedge clk); cyc_tick = 0; uv_low = 0;
    chk("R6 uv with tick exits", mode_hyst, 1'b0);
    chk("R8 chg on uv exit", mode_chg, 1'b1);
    for (int i = 0; i < 4; i++) sample(1'b1);
    chk("R10 stale count dropped", mode_hyst, 1'b0);
  endtask

  task automatic t_force();
    do_reset();
    force_pwm = 1;
    for (int i = 0; i < 10; i++) sample(1'b1);
    chk("R7 force holds PWM", mode_hyst, 1'b0);
    force_pwm = 0;
    for (int i = 0; i < 5; i++) sample(1'b1);
    force_pwm = 1; idle(1); force_pwm = 0;
    for (int i = 0; i < 3; i++) sample(1'b1);
    chk("R7 force clears run", mode_hyst, 1'b0);
    for (int i = 0; i < 5; i++) sample(1'b1);
    chk("R7 run after force", mode_hyst, 1'b1);
    idle(1);
    force_pwm = 1; @(negedge clk); force_pwm = 0;
    chk("R7 force exits hyst", mode_hyst, 1'b0);
    chk("R8 chg on force exit", mode_chg, 1'b1);
  endtask

  task automatic t_recount();
    do_reset();
    enter_hyst();
    for (int i = 0; i < 7; i++) sample(1'b0);
    chk("R10 hyst count starts fresh", mode_hyst, 1'b1);
  endtask

  initial begin
    rst_n = 0; cyc_tick = 0; smp_stb = 0; phase_pos = 0; uv_low = 0; force_pwm = 0;
    t_reset();
    t_enter();
    t_unstrobed();
    t_break();
    t_exit();
    t_uv();
    t_force();
    t_recount();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule